// File: doc/BRIEF.md
# System Clock Mode Controller with Hardware-Timed Switch-Up

This block derives the CPU internal clock from one of two oscillators and keeps track of which of three operating speeds is active. Fast and intermediate operation both come from the main oscillator, at ratios of 2 and 8. Slow operation comes from the sub oscillator, divided by 2. The whole block runs on one reference clock. Each oscillator is presented to it as a one-cycle tick input, and the internal clock leaves it as a one-cycle enable pulse (`phi_en`). One `phi_en` pulse is one machine cycle.

Software controls the block through two byte registers. The speed register sits at address 0 and holds the speed field, a main-oscillator stop bit and five auxiliary bits. The switch-control register sits at address 1. From slow operation, software can arm and fire a hardware sequence in one write. The sequence turns the main oscillator back on, lets a chosen number of machine cycles pass so that the oscillator can settle, and then rewrites the speed field to intermediate with no further software action.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, address 0 reads 8'h40 (intermediate speed, stop bit clear, auxiliary bits 0), address 1 reads 8'h00, and `main_osc_en` is 1.
- R2: The speed field occupies bits 7:6 of address 0, encoded 00 fast, 01 intermediate, 10 slow. In fast mode `phi_en` pulses on every second counted main tick. In intermediate mode it pulses on every eighth counted main tick. In slow mode it pulses on every second sub tick. Main ticks are counted only while `main_osc_en` is 1.
- R3: Address 1 holds the preload-control bit (bit 0), the arm bit (bit 1), the wait-select bit (bit 2) and the start bit (bit 3). Bits 0 to 2 read back as written. Bits 7:4 always read 0.
- R4: A sequence starts only on a write to address 1 that has both bit 3 and bit 1 set, made while the speed field is slow and no sequence is running. Any other such write leaves the start bit at 0 and the speed and oscillator state unchanged.
- R5: `main_osc_en` equals the inverse of the stop bit (address 0 bit 5), except that it is forced to 1 while a sequence is running. It is always 1 when the speed field is not slow.
- R6: With wait-select 0 the sequence waits 7 machine cycles, and with wait-select 1 it waits 5. These are counted as `phi_en` pulses after the starting write. In the cycle after the last counted pulse, address 0 reads intermediate speed with the stop bit clear.
- R7: The start bit reads 1 while a sequence is running and 0 once it has finished.
- R8: A write to address 0 is dropped as a whole when a sequence is running, when the speed field written is 11, or when fast or intermediate speed is written while the stop bit is set or is being set. A slow-speed write is otherwise always taken, together with its stop bit and auxiliary bits 4:0.
- R9: `phi_en` never pulses in two consecutive cycles unless the speed field changed between them.
- R10: Writing 0 to the start bit while a sequence is running neither cancels it nor changes its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all state |
| rst_n | input | 1 | Active-low synchronous reset |
| main_tick | input | 1 | One-cycle pulse per main oscillator period |
| sub_tick | input | 1 | One-cycle pulse per sub oscillator period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 speed register, 1 switch control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address, same map as writes |
| rd_data | output | 8 | Combinational read data |
| phi_en | output | 1 | Internal clock enable, one pulse per machine cycle |
| main_osc_en | output | 1 | Main oscillator run request |
| mode_field | output | 2 | Current speed field |

## Verification
Four properties are checked on every cycle: the spacing of `phi_en` pulses within one speed, the main oscillator being on whenever fast or intermediate speed is selected, a sequence being able to begin only from slow speed, and the speed and start bits after completion together with the speed field holding still while a sequence runs. The bench is needed for the exact division ratios, the precise 7- and 5-cycle wait lengths, the write-rejection rules, and the fact that a start-bit clear during the wait changes nothing. Its reference model compares every output on every cycle under two main-tick patterns.

// File: rtl/ckm_pkg.sv
package ckm_pkg;

  typedef enum logic [1:0] {
    SPD_FAST = 2'b00,
    SPD_MID  = 2'b01,
    SPD_SLOW = 2'b10,
    SPD_RSVD = 2'b11
  } ckm_speed_e;

  localparam logic ADR_SPEED = 1'b0;
  localparam logic ADR_SWCTL = 1'b1;

  localparam int BIT_PRELOAD = 0;
  localparam int BIT_ARM     = 1;
  localparam int BIT_WSEL    = 2;
  localparam int BIT_START   = 3;
  localparam int BIT_STOP    = 5;
  localparam int AUX_W       = 5;

  // Acceptance rule for a speed-register write.
  function automatic logic speed_write_ok(input logic busy, input logic cur_stop,
                                          input ckm_speed_e new_spd, input logic new_stop);
    if (busy)                  return 1'b0;
    if (new_spd == SPD_RSVD)   return 1'b0;
    if (new_spd == SPD_SLOW)   return 1'b1;
    return !cur_stop && !new_stop;
  endfunction

endpackage

// File: rtl/ckm_divider.sv
module ckm_divider
  import ckm_pkg::*;
#(
  parameter int FAST_DIV = 2,
  parameter int MID_DIV  = 8,
  parameter int SUB_DIV  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_tick,
  input  logic       sub_tick,
  input  logic       osc_on,
  input  ckm_speed_e speed,
  output logic       phi_en
);

  localparam int MW = (MID_DIV > 1) ? $clog2(MID_DIV) : 1;
  localparam int SW = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;

  logic [MW-1:0] main_cnt;
  logic [SW-1:0] sub_cnt;
  logic          main_cnt_en;
  logic          main_wrap;
  logic          sub_wrap;

  function automatic logic fast_hit(input logic [MW-1:0] c);
    return (int'(c) % FAST_DIV) == (FAST_DIV - 1);
  endfunction

  assign main_cnt_en = main_tick && osc_on;
  assign main_wrap   = (int'(main_cnt) == MID_DIV - 1);
  assign sub_wrap    = (int'(sub_cnt) == SUB_DIV - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_cnt <= '0;
      sub_cnt  <= '0;
    end else begin
      if (main_cnt_en) main_cnt <= main_wrap ? '0 : main_cnt + 1'b1;
      if (sub_tick)    sub_cnt  <= sub_wrap  ? '0 : sub_cnt + 1'b1;
    end
  end

  always_comb begin
    unique case (speed)
      SPD_FAST: phi_en = main_cnt_en && fast_hit(main_cnt);
      SPD_MID:  phi_en = main_cnt_en && main_wrap;
      SPD_SLOW: phi_en = sub_tick && sub_wrap;
      default:  phi_en = 1'b0;
    endcase
  end

  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(main_cnt) < MID_DIV);

  a_r9_phi_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    phi_en |=> (!phi_en || !$stable(speed)));

endmodule

// File: rtl/ckm_sequencer.sv
module ckm_sequencer #(
  parameter int LONG_WAIT  = 7,
  parameter int SHORT_WAIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic short_sel,
  input  logic phi_en,
  output logic busy,
  output logic done
);

  localparam int MAXW = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT;
  localparam int CW   = $clog2(MAXW + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] target;
  logic          last_cycle;

  function automatic logic [CW-1:0] wait_len(input logic s);
    return s ? CW'(SHORT_WAIT) : CW'(LONG_WAIT);
  endfunction

  assign last_cycle = (cnt == target - 1'b1);
  assign done       = busy && phi_en && last_cycle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      target <= wait_len(1'b0);
    end else if (launch) begin
      busy   <= 1'b1;
      cnt    <= '0;
      target <= wait_len(short_sel);
    end else if (busy && phi_en) begin
      if (last_cycle) busy <= 1'b0;
      else            cnt  <= cnt + 1'b1;
    end
  end

  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < target));

  a_r6_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);

endmodule

// File: rtl/ckm_regfile.sv
module ckm_regfile
  import ckm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_addr,
  output logic [7:0] rd_data,
  input  logic       busy,
  input  logic       done,
  output logic       launch,
  output logic       short_sel,
  output ckm_speed_e speed,
  output logic       stop
);

  logic [AUX_W-1:0] aux_q;
  logic             preload_q;
  logic             arm_q;
  logic             wsel_q;
  logic             start_q;
  logic             spd_wr;
  logic             ctl_wr;
  logic             spd_ok;
  ckm_speed_e       new_spd;

  assign spd_wr    = wr_en && (wr_addr == ADR_SPEED);
  assign ctl_wr    = wr_en && (wr_addr == ADR_SWCTL);
  assign new_spd   = ckm_speed_e'(wr_data[7:6]);
  assign spd_ok    = speed_write_ok(busy, stop, new_spd, wr_data[BIT_STOP]);
  assign launch    = ctl_wr && wr_data[BIT_START] && wr_data[BIT_ARM]
                     && (speed == SPD_SLOW) && !busy;
  assign short_sel = wr_data[BIT_WSEL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      speed <= SPD_MID;
      stop  <= 1'b0;
      aux_q <= '0;
    end else if (done) begin
      speed <= SPD_MID;
      stop  <= 1'b0;
    end else if (spd_wr && spd_ok) begin
      speed <= new_spd;
      stop  <= wr_data[BIT_STOP];
      aux_q <= wr_data[AUX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preload_q <= 1'b0;
      arm_q     <= 1'b0;
      wsel_q    <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      if (ctl_wr) begin
        preload_q <= wr_data[BIT_PRELOAD];
        arm_q     <= wr_data[BIT_ARM];
        wsel_q    <= wr_data[BIT_WSEL];
      end
      start_q <= launch || (start_q && !done);
    end
  end

  always_comb begin
    if (rd_addr == ADR_SPEED) rd_data = {speed, stop, aux_q};
    else                      rd_data = {4'b0000, start_q, wsel_q, arm_q, preload_q};
  end

  a_r6_done_mid: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (speed == SPD_MID) && !stop);

  a_r7_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !start_q);

  a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(speed));

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import ckm_pkg::*;
#(
  parameter int FAST_DIV   = 2,
  parameter int MID_DIV    = 8,
  parameter int SUB_DIV    = 2,
  parameter int LONG_WAIT  = 7,
  parameter int SHORT_WAIT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_tick,
  input  logic       sub_tick,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_addr,
  output logic [7:0] rd_data,
  output logic       phi_en,
  output logic       main_osc_en,
  output logic [1:0] mode_field
);

  ckm_speed_e speed;
  logic       stop;
  logic       busy;
  logic       done;
  logic       launch;
  logic       short_sel;

  assign main_osc_en = !stop || busy;
  assign mode_field  = speed;

  ckm_divider #(
    .FAST_DIV (FAST_DIV),
    .MID_DIV  (MID_DIV),
    .SUB_DIV  (SUB_DIV)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .main_tick (main_tick),
    .sub_tick  (sub_tick),
    .osc_on    (main_osc_en),
    .speed     (speed),
    .phi_en    (phi_en)
  );

  ckm_sequencer #(
    .LONG_WAIT  (LONG_WAIT),
    .SHORT_WAIT (SHORT_WAIT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .short_sel (short_sel),
    .phi_en    (phi_en),
    .busy      (busy),
    .done      (done)
  );

  ckm_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .busy      (busy),
    .done      (done),
    .launch    (launch),
    .short_sel (short_sel),
    .speed     (speed),
    .stop      (stop)
  );

  a_r5_osc_on_main: assert property (@(posedge clk) disable iff (!rst_n)
    (speed != SPD_SLOW) |-> main_osc_en);

  a_r4_start_from_slow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(speed) == SPD_SLOW));

endmodule

// File: tb/test_clk_mode_ctrl.sv
module test_clk_mode_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_tick = 1'b0, sub_tick = 1'b0;
  logic       wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       phi_en, main_osc_en;
  logic [1:0] mode_field;

  int checks = 0, errors = 0, cyc = 0;
  int main_pat = 0;

  // reference model state
  int m_spd = 1, m_stop = 0, m_aux = 0;
  int m_pre = 0, m_arm = 0, m_wsel = 0, m_start = 0;
  int m_busy = 0, m_cnt = 0, m_target = 7, m_mcnt = 0, m_scnt = 0;
  bit last_phi;

  always #10 clk = ~clk;

  clk_mode_ctrl i_clk_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .phi_en(phi_en), .main_osc_en(main_osc_en),
    .mode_field(mode_field)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input bit w, input bit a, input int d);
    bit osc, phi, done, mt, st, sok, launch;
    int nspd, nstop;
    @(negedge clk);
    mt = (main_pat == 0) ? 1'b1 : ((cyc % 3) != 2);
    st = ((cyc % 5) == 0);
    wr_en = w; wr_addr = a; wr_data = d[7:0];
    main_tick = mt; sub_tick = st;
    #2;
    osc = (m_stop == 0) || (m_busy != 0);
    case (m_spd)
      0: phi = mt && osc && ((m_mcnt % 2) == 1);
      1: phi = mt && osc && (m_mcnt == 7);
      2: phi = st && (m_scnt == 1);
      default: phi = 1'b0;
    endcase
    check("R2/R9 phi_en", phi_en, phi);
    check("R5 main_osc_en", main_osc_en, osc);
    check("R2 mode_field", mode_field, m_spd);
    if (rd_addr == 1'b0) check("R8 speed reg", rd_data, m_spd * 64 + m_stop * 32 + m_aux);
    else check("R3 switch reg", rd_data, m_start * 8 + m_wsel * 4 + m_arm * 2 + m_pre);
    last_phi = phi;
    // model state update for the coming edge
    done = (m_busy != 0) && phi && (m_cnt == m_target - 1);
    launch = w && a && d[3] && d[1] && (m_spd == 2) && (m_busy == 0);
    nspd = (d >> 6) & 3; nstop = (d >> 5) & 1;
    sok = (m_busy == 0) && (nspd != 3) && ((nspd == 2) || (m_stop == 0 && nstop == 0));
    if (mt && osc) m_mcnt = (m_mcnt + 1) % 8;
    if (st) m_scnt = 1 - m_scnt;
    if (done) begin m_spd = 1; m_stop = 0; end
    else if (w && !a && sok) begin m_spd = nspd; m_stop = nstop; m_aux = d & 31; end
    if (w && a) begin m_pre = d & 1; m_arm = (d >> 1) & 1; m_wsel = (d >> 2) & 1; end
    m_start = (launch || (m_start != 0 && !done)) ? 1 : 0;
    if (launch) begin m_busy = 1; m_cnt = 0; m_target = d[2] ? 5 : 7; end
    else if (m_busy != 0 && phi) begin
      if (m_cnt == m_target - 1) m_busy = 0; else m_cnt++;
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic count_phi(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0);
      if (phi_en) cnt++;
    end
  endtask

  task automatic run_switch(input int ctl, input int exp_len, input string tag);
    int pulses, guard;
    step(1, 0, 8'hB5);                    // slow, stop set, aux 0x15
    rd_addr = 1'b0; step(0, 0, 0);
    check("R5 osc off when stopped", main_osc_en, 0);
    check("R8 slow write taken", rd_data, 8'hB5);
    step(1, 0, 8'h00);                    // fast while stopped: dropped
    step(1, 0, 8'hC0);                    // reserved: dropped
    step(0, 0, 0);
    check("R8 rejected writes", rd_data, 8'hB5);
    rd_addr = 1'b1;
    step(1, 1, 8'h08);                    // start without arm
    step(0, 0, 0);
    check("R4 start without arm ignored", rd_data, 8'h00);
    check("R4 osc unchanged", main_osc_en, 0);
    step(1, 1, ctl);
    pulses = 0; guard = 0;
    step(0, 0, 0);
    check("R5 osc forced on", main_osc_en, 1);
    check("R7 start reads 1", (rd_data >> 3) & 1, 1);
    if (phi_en) pulses++;
    step(1, 1, ctl & 8'h07);              // clear start mid-sequence
    if (phi_en && ((rd_data >> 3) & 1)) pulses++;
    step(1, 0, 8'h20);                    // speed write while busy
    if (phi_en && ((rd_data >> 3) & 1)) pulses++;
    while (((rd_data >> 3) & 1) && guard < 400) begin
      step(0, 0, 0); guard++;
      if (phi_en && ((rd_data >> 3) & 1)) pulses++;
    end
    check({tag, " R6 wait length R10"}, pulses, exp_len);
    check("R7 start reads 0 after", (rd_data >> 3) & 1, 0);
    check("R3 bits kept", rd_data, ctl & 8'h07);
    rd_addr = 1'b0; step(0, 0, 0);
    check("R6 speed is mid, stop clear", rd_data, 8'h55);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_addr = 1'b0; step(0, 0, 0);
    check("R1 speed reg reset", rd_data, 8'h40);
    check("R1 osc en reset", main_osc_en, 1);
    rd_addr = 1'b1; step(0, 0, 0);
    check("R1 switch reg reset", rd_data, 8'h00);
    step(1, 1, 8'hFB);                    // not slow: no start
    step(0, 0, 0);
    check("R3 R4 readback", rd_data, 8'h03);
    rd_addr = 1'b0;
    step(1, 0, 8'h00); idle(2);
    count_phi(40, n); check("R2 fast ratio", n, 20);
    step(1, 0, 8'h40); idle(2);
    count_phi(40, n); check("R2 mid ratio", n, 5);
    step(1, 0, 8'h80); idle(2);
    count_phi(40, n); check("R2 slow ratio", n, 4);
    run_switch(8'h0A, 7, "long");
    main_pat = 1;
    run_switch(8'h0E, 5, "short");
    step(1, 0, 8'h00); idle(50);
    step(1, 0, 8'h40); idle(50);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule